// File: doc/BRIEF.md
# Clock Correction Sequence Detector

This block watches a received symbol stream, one symbol per clock, and flags the moment a configured clock-correction sequence has just been completed. Each symbol arrives with its undecoded 10-bit line code, its decoded 8-bit value, a K-character flag and a disparity-error flag. A downstream elastic buffer uses the detect pulse to decide where an idle may be inserted or removed. That buffer is not part of this block.

The configuration holds two banks of four 11-bit pattern words, a sequence length, a second-sequence enable and an 8-bit word mask. A short sequence has a length of 1 to 4. For a short sequence, bank 1 is the primary pattern and bank 2 can act as an alternative pattern. A length of 8 joins the two banks into one long sequence. The top bit of each pattern word selects one of two compares: against the decoded fields, or against the raw code.

Only symbols qualified by the input-valid flag enter the comparison history. Idle cycles therefore neither advance nor break a partial match.

Top module: `ccseq_detect`

## Requirements
- R1: Only the length settings 1, 2, 3, 4 and 8 are legal. With any other value on `cfg_len`, `det` stays 0.
- R2: A pattern word with bit 10 = 0 is a decoded compare. It matches only when bit 9 equals `in_derr`, bit 8 equals `in_k` and bits 7:0 equal `in_data`.
- R3: A pattern word with bit 10 = 1 is a raw compare. It matches only when bits 9:0 equal `in_raw`; the decoded fields are not looked at.
- R4: For a length L of 1 to 4, bank 1 word j (bits 11j-1:11j-11 of `cfg_bank1`) is compared with the symbol received L-j valid symbols before the newest one. Word 1 is therefore the earliest symbol, and the same symbols in another order do not match.
- R5: For lengths 1 to 4 with `cfg_seq2_en` = 1, a match of bank 2 (same alignment) also detects. `det_bank` is 1 only when bank 2 matched and bank 1 did not, and is 0 in every other detection. With `cfg_seq2_en` = 0, bank 2 is ignored.
- R6: With length 8, bank 1 words 1 to 4 must match the four earliest of the last eight valid symbols and bank 2 words 1 to 4 the four latest. `det_bank` reads 0. If `cfg_seq2_en` = 0, nothing is detected.
- R7: When `cfg_mask` bit i is 1, the corresponding word is left out of the compare. Bits 3:0 map to bank 1 words 1 to 4 and bits 7:4 map to bank 2 words 1 to 4. For a short length, words beyond L are always left out.
- R8: `det` is high only in the cycle in which the final symbol of a matching sequence is presented with `in_valid` = 1.
- R9: Overlapping and back-to-back sequences are each detected.
- R10: Synchronous reset `rst` clears the history. While `rst` is high, `det` = 0. After reset, nothing is detected until L valid symbols have been received.
- R11: A cycle with `in_valid` = 0 gives `det` = 0 and leaves the history unchanged, so a partial match survives idles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The symbol on the inputs is valid this cycle |
| in_raw | input | 10 | Undecoded line code |
| in_data | input | 8 | Decoded data value |
| in_k | input | 1 | Decoded symbol is a K character |
| in_derr | input | 1 | Disparity error on this symbol |
| cfg_bank1 | input | 44 | Bank 1 pattern words; word j is in bits 11j-1:11j-11 |
| cfg_bank2 | input | 44 | Bank 2 pattern words, same layout |
| cfg_len | input | 4 | Sequence length |
| cfg_seq2_en | input | 1 | Enables bank 2 as an alternative pattern or as the tail of the long sequence |
| cfg_mask | input | 8 | Per-word compare exclusion |
| det | output | 1 | The sequence ended with this symbol |
| det_bank | output | 1 | 0 = bank 1 (or the long sequence) matched, 1 = only bank 2 matched |

## Verification
Single-word patterns are tried in two ways: with one decoded field changed at a time, and with raw codes differing in a single bit. These show that each compare mode looks at exactly its own fields. Four-symbol patterns are sent in order, reversed, split by idles, interrupted by reset and repeated back-to-back. These separate word alignment, history gating and the fill rule after reset. Alternative-bank, long-chain, masked-word, self-overlapping and illegal-length stimuli confirm bank selection, the enable dependence of the long sequence, mask exclusion, overlapped detection and suppression under illegal lengths.

// File: rtl/ccseq_pkg.sv
package ccseq_pkg;

  localparam int unsigned RAW_W      = 10;
  localparam int unsigned DAT_W      = 8;
  localparam int unsigned PAT_W      = RAW_W + 1;
  localparam int unsigned BANK_WORDS = 4;
  localparam int unsigned HIST_DEPTH = 2 * BANK_WORDS;
  localparam int unsigned LEN_W      = 4;
  localparam int unsigned AGE_W      = $clog2(HIST_DEPTH);

  typedef struct packed {
    logic             derr;
    logic             k;
    logic [DAT_W-1:0] data;
    logic [RAW_W-1:0] raw;
  } sym_t;

  // One pattern word against one symbol; top bit selects raw or decoded compare.
  function automatic logic word_hit(input logic [PAT_W-1:0] pat, input sym_t s);
    if (pat[PAT_W-1])
      return pat[RAW_W-1:0] == s.raw;
    return pat[RAW_W-1:0] == {s.derr, s.k, s.data};
  endfunction

  function automatic logic len_is_short(input logic [LEN_W-1:0] len);
    return (len >= LEN_W'(1)) && (len <= LEN_W'(BANK_WORDS));
  endfunction

  function automatic logic len_is_long(input logic [LEN_W-1:0] len);
    return len == LEN_W'(HIST_DEPTH);
  endfunction

  // Age (0 = newest) of the symbol that pattern word idx of a bank is aligned to.
  function automatic logic [AGE_W-1:0] align_age(input logic [LEN_W-1:0] len,
                                                 input int unsigned idx,
                                                 input logic long_mode,
                                                 input logic second_bank);
    int a;
    if (long_mode)
      a = second_bank ? int'(BANK_WORDS) - 1 - int'(idx)
                      : int'(HIST_DEPTH) - 1 - int'(idx);
    else if (int'(idx) < int'(len))
      a = int'(len) - 1 - int'(idx);
    else
      a = 0;
    return AGE_W'(a);
  endfunction

endpackage

// File: rtl/ccseq_hist.sv
module ccseq_hist
  import ccseq_pkg::*;
#(
  parameter int unsigned DEPTH = HIST_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  sym_t             din,
  output sym_t             win [DEPTH],
  output logic [CNT_W-1:0] fill
);

  sym_t stored [DEPTH-1];

  assign win[0] = din;

  for (genvar a = 1; a < DEPTH; a++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst)
        stored[a-1] <= '0;
      else if (push)
        stored[a-1] <= (a == 1) ? din : stored[a-2];
    end
    assign win[a] = stored[a-1];
  end

  always_ff @(posedge clk) begin
    if (rst)
      fill <= '0;
    else if (push && fill != CNT_W'(DEPTH - 1))
      fill <= fill + CNT_W'(1);
  end

endmodule

// File: rtl/ccseq_lendec.sv
module ccseq_lendec
  import ccseq_pkg::*;
#(
  parameter int unsigned LW = LEN_W
) (
  input  logic [LW-1:0] len,
  output logic          short_mode,
  output logic          long_mode,
  output logic          legal
);

  assign short_mode = len_is_short(len);
  assign long_mode  = len_is_long(len);
  assign legal      = short_mode | long_mode;

endmodule

// File: rtl/ccseq_bank_cmp.sv
module ccseq_bank_cmp
  import ccseq_pkg::*;
#(
  parameter int unsigned WORDS = BANK_WORDS,
  parameter int unsigned PW    = PAT_W
) (
  input  logic [WORDS*PW-1:0] pat,
  input  sym_t                sym [WORDS],
  input  logic [WORDS-1:0]    use_word,
  output logic                hit
);

  logic [WORDS-1:0] ok;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign ok[i] = !use_word[i] || word_hit(pat[i*PW +: PW], sym[i]);
  end

  assign hit = &ok;

endmodule

// File: rtl/ccseq_detect.sv
module ccseq_detect
  import ccseq_pkg::*;
#(
  parameter int unsigned NW = BANK_WORDS,
  localparam int unsigned DEPTH = 2 * NW,
  localparam int unsigned CNT_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [RAW_W-1:0]    in_raw,
  input  logic [DAT_W-1:0]    in_data,
  input  logic                in_k,
  input  logic                in_derr,
  input  logic [NW*PAT_W-1:0] cfg_bank1,
  input  logic [NW*PAT_W-1:0] cfg_bank2,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_seq2_en,
  input  logic [DEPTH-1:0]    cfg_mask,
  output logic                det,
  output logic                det_bank
);

  sym_t             cur;
  sym_t             win [DEPTH];
  logic [CNT_W-1:0] fill;
  logic             short_mode, long_mode, legal;
  sym_t             b1_sym [NW];
  sym_t             b2_sym [NW];
  logic [NW-1:0]    b1_use, b2_use;
  logic             ev_hit1, ev_hit2, ev_enough, ev_short_det, ev_long_det;

  assign cur = '{derr: in_derr, k: in_k, data: in_data, raw: in_raw};

  ccseq_hist #(.DEPTH(DEPTH)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .push (in_valid && !rst),
    .din  (cur),
    .win  (win),
    .fill (fill)
  );

  ccseq_lendec #(.LW(LEN_W)) u_len (
    .len        (cfg_len),
    .short_mode (short_mode),
    .long_mode  (long_mode),
    .legal      (legal)
  );

  for (genvar i = 0; i < NW; i++) begin : g_align
    assign b1_sym[i] = win[align_age(cfg_len, i, long_mode, 1'b0)];
    assign b2_sym[i] = win[align_age(cfg_len, i, long_mode, 1'b1)];
    assign b1_use[i] = !cfg_mask[i]      && (long_mode || (i < int'(cfg_len)));
    assign b2_use[i] = !cfg_mask[NW + i] && (long_mode || (i < int'(cfg_len)));
  end

  ccseq_bank_cmp #(.WORDS(NW), .PW(PAT_W)) u_cmp1 (
    .pat      (cfg_bank1),
    .sym      (b1_sym),
    .use_word (b1_use),
    .hit      (ev_hit1)
  );

  ccseq_bank_cmp #(.WORDS(NW), .PW(PAT_W)) u_cmp2 (
    .pat      (cfg_bank2),
    .sym      (b2_sym),
    .use_word (b2_use),
    .hit      (ev_hit2)
  );

  // Stored valid symbols plus the current one must cover the whole sequence.
  assign ev_enough    = legal && ({1'b0, fill} + (CNT_W+1)'(1) >= (CNT_W+1)'(cfg_len));
  assign ev_short_det = short_mode && (ev_hit1 || (cfg_seq2_en && ev_hit2));
  assign ev_long_det  = long_mode && cfg_seq2_en && ev_hit1 && ev_hit2;

  always_comb begin
    det      = !rst && in_valid && ev_enough && (ev_short_det || ev_long_det);
    det_bank = det && short_mode && !ev_hit1;
  end

endmodule

// File: rtl/ccseq_chk.sv
module ccseq_chk
  import ccseq_pkg::*;
#(
  parameter int unsigned NW = BANK_WORDS
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [RAW_W-1:0]    in_raw,
  input logic [DAT_W-1:0]    in_data,
  input logic                in_k,
  input logic                in_derr,
  input logic [NW*PAT_W-1:0] cfg_bank1,
  input logic [LEN_W-1:0]    cfg_len,
  input logic                cfg_seq2_en,
  input logic [2*NW-1:0]     cfg_mask,
  input logic                det,
  input logic                det_bank
);

  logic len_ok;
  assign len_ok = ((cfg_len >= LEN_W'(1)) && (cfg_len <= LEN_W'(NW))) || (cfg_len == LEN_W'(2*NW));

  assert_illegal_len_R1: assert property (@(posedge clk) disable iff (rst)
    !len_ok |-> !det);

  assert_decoded_word_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_len == LEN_W'(1) && !cfg_mask[0] && !cfg_bank1[PAT_W-1]
     && cfg_bank1[RAW_W-1:0] == {in_derr, in_k, in_data}) |-> det);

  assert_raw_word_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_len == LEN_W'(1) && !cfg_mask[0] && cfg_bank1[PAT_W-1]
     && cfg_bank1[RAW_W-1:0] == in_raw) |-> det);

  assert_bank2_only_R5: assert property (@(posedge clk) disable iff (rst)
    det_bank |-> (det && cfg_seq2_en && cfg_len <= LEN_W'(NW)));

  assert_long_needs_seq2_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_len == LEN_W'(2*NW) && !cfg_seq2_en) |-> !det);

  assert_det_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    det |-> in_valid);

  assert_fill_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
    (det && $past(rst)) |-> cfg_len == LEN_W'(1));

endmodule

bind ccseq_detect ccseq_chk #(.NW(NW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_raw      (in_raw),
  .in_data     (in_data),
  .in_k        (in_k),
  .in_derr     (in_derr),
  .cfg_bank1   (cfg_bank1),
  .cfg_len     (cfg_len),
  .cfg_seq2_en (cfg_seq2_en),
  .cfg_mask    (cfg_mask),
  .det         (det),
  .det_bank    (det_bank)
);

// File: tb/sim_ccseq_detect.sv
`timescale 1ns/1ps
module sim_ccseq_detect;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [9:0]  in_raw = '0;
  logic [7:0]  in_data = '0;
  logic        in_k = 1'b0;
  logic        in_derr = 1'b0;
  logic [43:0] cfg_bank1 = '0;
  logic [43:0] cfg_bank2 = '0;
  logic [3:0]  cfg_len = 4'd1;
  logic        cfg_seq2_en = 1'b0;
  logic [7:0]  cfg_mask = '0;
  logic        det, det_bank;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ccseq_detect u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_raw(in_raw), .in_data(in_data),
    .in_k(in_k), .in_derr(in_derr), .cfg_bank1(cfg_bank1), .cfg_bank2(cfg_bank2),
    .cfg_len(cfg_len), .cfg_seq2_en(cfg_seq2_en), .cfg_mask(cfg_mask),
    .det(det), .det_bank(det_bank)
  );

  function automatic logic [10:0] pd(input bit e, input bit k, input logic [7:0] d);
    return {1'b0, e, k, d};
  endfunction
  function automatic logic [10:0] pr(input logic [9:0] r);
    return {1'b1, r};
  endfunction
  function automatic logic [9:0] raw_of(input logic [7:0] d);
    return {2'b10, d} ^ 10'h0A5;
  endfunction
  function automatic logic [43:0] bank(input logic [7:0] a, input logic [7:0] b,
                                      input logic [7:0] c, input logic [7:0] d);
    return {pd(0, 0, d), pd(0, 0, c), pd(0, 0, b), pd(0, 0, a)};
  endfunction

  task automatic check(input bit exp, input bit expb, input string tag);
    nvec++;
    if (det !== exp) begin
      nbad++;
      $display("FAIL %s: det=%b expected %b", tag, det, exp);
    end else if (exp && det_bank !== expb) begin
      nbad++;
      $display("FAIL %s: det_bank=%b expected %b", tag, det_bank, expb);
    end
  endtask

  task automatic drive(input logic [9:0] r, input logic [7:0] d, input bit k, input bit e,
                       input bit exp, input bit expb, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_raw = r; in_data = d; in_k = k; in_derr = e;
    #5 check(exp, expb, tag);
  endtask

  task automatic sym(input logic [7:0] d, input bit exp, input bit expb, input string tag);
    drive(raw_of(d), d, 1'b0, 1'b0, exp, expb, tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    #5 check(1'b0, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    cfg_len = 4'd1; cfg_mask = '0; cfg_seq2_en = 0;
    cfg_bank1 = bank(8'h55, 0, 0, 0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_raw = raw_of(8'h55); in_data = 8'h55; in_k = 0; in_derr = 0;
    #5 check(1'b0, 1'b0, "R10 det low in reset");
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    cfg_len = 4'd4; cfg_bank1 = bank(8'h41, 8'h42, 8'h43, 8'h44);
    sym(8'h41, 0, 0, "R10 pre a");
    sym(8'h42, 0, 0, "R10 pre b");
    do_reset();
    sym(8'h43, 0, 0, "R10 history cleared c");
    sym(8'h44, 0, 0, "R10 history cleared d");
    do_reset();
    sym(8'h44, 0, 0, "R10 fill one symbol");
  endtask

  task automatic t_decoded();
    do_reset();
    cfg_len = 4'd1; cfg_mask = '0; cfg_seq2_en = 0;
    cfg_bank1 = {33'd0, pd(0, 1, 8'hBC)};
    drive(raw_of(8'hBC), 8'hBC, 1, 0, 1, 0, "R2 decoded match");
    drive(raw_of(8'hBC), 8'hBC, 0, 0, 0, 0, "R2 k flag differs");
    drive(raw_of(8'hBC), 8'hBC, 1, 1, 0, 0, "R2 derr differs");
    drive(raw_of(8'hBD), 8'hBD, 1, 0, 0, 0, "R2 data differs");
  endtask

  task automatic t_raw();
    do_reset();
    cfg_len = 4'd1; cfg_mask = '0;
    cfg_bank1 = {33'd0, pr(10'h17C)};
    drive(10'h17C, 8'h00, 0, 1, 1, 0, "R3 raw match");
    drive(10'h17D, 8'h7C, 1, 0, 0, 0, "R3 raw one bit off");
  endtask

  task automatic t_order();
    do_reset();
    cfg_len = 4'd4; cfg_mask = '0; cfg_seq2_en = 0;
    cfg_bank1 = bank(8'h41, 8'h42, 8'h43, 8'h44);
    sym(8'h44, 0, 0, "R4 reversed 1");
    sym(8'h43, 0, 0, "R4 reversed 2");
    sym(8'h42, 0, 0, "R4 reversed 3");
    sym(8'h41, 0, 0, "R4 reversed 4");
    sym(8'h41, 0, 0, "R4 in order 1");
    sym(8'h42, 0, 0, "R4 in order 2");
    sym(8'h43, 0, 0, "R4 in order 3");
    sym(8'h44, 1, 0, "R4 in order end");
    sym(8'h41, 0, 0, "R9 back-to-back 1");
    sym(8'h42, 0, 0, "R9 back-to-back 2");
    sym(8'h43, 0, 0, "R9 back-to-back 3");
    sym(8'h44, 1, 0, "R9 back-to-back end");
    sym(8'h41, 0, 0, "R11 gap a");
    sym(8'h42, 0, 0, "R11 gap b");
    idle("R11 idle no det");
    idle("R11 idle no det 2");
    sym(8'h43, 0, 0, "R11 gap c");
    sym(8'h44, 1, 0, "R11 gap end");
  endtask

  task automatic t_overlap();
    do_reset();
    cfg_len = 4'd2; cfg_mask = '0; cfg_seq2_en = 0;
    cfg_bank1 = bank(8'h70, 8'h70, 8'h00, 8'h00);
    sym(8'h70, 0, 0, "R9 overlap first");
    sym(8'h70, 1, 0, "R9 overlap second");
    sym(8'h70, 1, 0, "R9 overlap third");
  endtask

  task automatic t_alt();
    do_reset();
    cfg_len = 4'd2; cfg_mask = '0; cfg_seq2_en = 1;
    cfg_bank1 = bank(8'h21, 8'h22, 8'h00, 8'h00);
    cfg_bank2 = bank(8'h31, 8'h32, 8'h00, 8'h00);
    sym(8'h31, 0, 0, "R5 alt c");
    sym(8'h32, 1, 1, "R5 bank2 match");
    sym(8'h21, 0, 0, "R5 prim a");
    sym(8'h22, 1, 0, "R5 bank1 match");
    cfg_seq2_en = 0;
    sym(8'h31, 0, 0, "R5 disabled c");
    sym(8'h32, 0, 0, "R5 bank2 ignored");
  endtask

  task automatic t_long();
    do_reset();
    cfg_len = 4'd8; cfg_mask = '0; cfg_seq2_en = 1;
    cfg_bank1 = bank(8'h11, 8'h12, 8'h13, 8'h14);
    cfg_bank2 = bank(8'h15, 8'h16, 8'h17, 8'h18);
    for (int i = 0; i < 7; i++) sym(8'h11 + 8'(i), 0, 0, "R6 long partial");
    sym(8'h18, 1, 0, "R6 long end");
    cfg_seq2_en = 0;
    for (int i = 0; i < 7; i++) sym(8'h11 + 8'(i), 0, 0, "R6 long partial off");
    sym(8'h18, 0, 0, "R6 long without enable");
  endtask

  task automatic t_mask();
    do_reset();
    cfg_len = 4'd3; cfg_seq2_en = 0;
    cfg_bank1 = bank(8'h51, 8'h52, 8'h53, 8'h99);
    cfg_mask = 8'b0000_0000;
    sym(8'h51, 0, 0, "R7 unmasked a");
    sym(8'h00, 0, 0, "R7 unmasked z");
    sym(8'h53, 0, 0, "R7 middle word compared");
    cfg_mask = 8'b0000_0010;
    sym(8'h51, 0, 0, "R7 masked a");
    sym(8'h00, 0, 0, "R7 masked z");
    sym(8'h53, 1, 0, "R7 middle word masked");
  endtask

  task automatic t_illegal();
    do_reset();
    cfg_mask = '0; cfg_seq2_en = 1;
    cfg_bank1 = bank(8'h61, 8'h61, 8'h61, 8'h61);
    cfg_bank2 = bank(8'h61, 8'h61, 8'h61, 8'h61);
    cfg_len = 4'd5;
    for (int i = 0; i < 8; i++) sym(8'h61, 0, 0, "R1 length 5");
    cfg_len = 4'd0;
    sym(8'h61, 0, 0, "R1 length 0");
    cfg_len = 4'd15;
    sym(8'h61, 0, 0, "R1 length 15");
    cfg_len = 4'd4;
    sym(8'h61, 1, 0, "R1 length 4 legal");
  endtask

  initial begin
    do_reset();
    t_reset();
    t_decoded();
    t_raw();
    t_order();
    t_overlap();
    t_alt();
    t_long();
    t_mask();
    t_illegal();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #4ms;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule